// File: doc/BRIEF.md
# Dual-Bank Address Generator

This block computes load/store addresses for a DSP datapath. It holds sixteen index registers and sixteen modify registers, split into two banks. Registers 0 to 7 of each kind belong to the data-memory space and registers 8 to 15 belong to the program-memory space. Each request names a memory space, an index register and an offset. The offset is either a modify register or a signed immediate. A mode bit chooses between two behaviours. Pre-modify emits index plus offset and leaves the index as it was. Post-modify emits the index and then stores index plus offset back into it.

A request can also be a modify-only operation. It updates the index by the offset and makes no memory access. This lets software build a pre-decrement out of a modify followed by a zero-offset access. A separate write port loads any index or modify register.

A request whose registers come from the bank of the other memory space is rejected. It produces no address and no writeback, and it raises an error pulse instead.

Top module: `dag_dual_bank`

## Requirements
- R1: After reset every index register is 0, modify register 6 holds +1, modify register 7 holds -1 (all ones), every other modify register is 0, and `addr_valid` and `bad_req` are low.
- R2: A legal access with `acc_post`=0 (pre-modify) gives `addr_out` = index + offset and leaves the index register unchanged.
- R3: A legal access with `acc_post`=1 (post-modify) gives `addr_out` = the index value before the request, and the index register becomes index + offset.
- R4: When `acc_use_imm`=1 the offset is `acc_imm`, taken as a signed 32-bit value. In that case `acc_msel` is ignored, both as an offset source and in the bank check.
- R5: A register select belongs to bank `sel[3]`. A request is legal only if `acc_isel[3]` equals `acc_space` (0 = data, 1 = program) and, when no immediate is used, `acc_msel[3]` also equals `acc_space`. An illegal request gives `bad_req`=1 and `addr_valid`=0, and it changes no register.
- R6: A legal request with `acc_nomem`=1 writes index + offset into the index register and leaves `addr_valid` low.
- R7: `wr_en` writes `wr_data` into modify register `wr_sel` (when `wr_is_mod`=1) or index register `wr_sel` (when `wr_is_mod`=0). The new value is used by requests from the next cycle on. If a writeback targets the same index register in the same cycle, the writeback value is kept.
- R8: Index + offset wraps modulo 2^32.
- R9: `addr_out`, `addr_valid` and `bad_req` are registered. They reflect the request sampled at the previous clock edge, and each `bad_req` pulse lasts one cycle per illegal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Request strobe |
| acc_space | input | 1 | Memory space: 0 data, 1 program |
| acc_isel | input | 4 | Index register number |
| acc_msel | input | 4 | Modify register number |
| acc_post | input | 1 | 1 post-modify, 0 pre-modify |
| acc_nomem | input | 1 | Modify-only operation, no address |
| acc_use_imm | input | 1 | Use immediate as offset |
| acc_imm | input | 32 | Signed immediate offset |
| wr_en | input | 1 | Register write strobe |
| wr_is_mod | input | 1 | 1 writes a modify register, 0 an index register |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| addr_out | output | 32 | Generated address |
| addr_valid | output | 1 | Address valid |
| bad_req | output | 1 | Illegal bank combination |

## Verification
All three results of a request come one clock edge after it is sampled. The bench drives each request on a falling edge and reads `addr_out`, `addr_valid` and `bad_req` on the next falling edge. A register update made at the same edge as the output is seen only through a later request. For that reason the bench reads index and modify registers back with zero-offset pre-modify accesses issued in later cycles, never in the request's own cycle. The single-cycle error pulse is checked one further falling edge after the illegal request.

// File: rtl/dag_dual_bank.sv
module dag_dual_bank #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic                          acc_space,
  input  logic [$clog2(2*NREG)-1:0]     acc_isel,
  input  logic [$clog2(2*NREG)-1:0]     acc_msel,
  input  logic                          acc_post,
  input  logic                          acc_nomem,
  input  logic                          acc_use_imm,
  input  logic [DW-1:0]                 acc_imm,
  input  logic                          wr_en,
  input  logic                          wr_is_mod,
  input  logic [$clog2(2*NREG)-1:0]     wr_sel,
  input  logic [DW-1:0]                 wr_data,
  output logic [DW-1:0]                 addr_out,
  output logic                          addr_valid,
  output logic                          bad_req
);
  localparam int NTOT    = 2 * NREG;
  localparam int SW      = $clog2(NTOT);
  localparam int UP_SLOT = 6;
  localparam int DN_SLOT = 7;

  logic [DW-1:0] ireg [NTOT];
  logic [DW-1:0] mreg [NTOT];
  logic [DW-1:0] offset, cur_idx, sum;
  logic          req_ok, wb_en;

  assign req_ok  = (acc_isel[SW-1] == acc_space) &&
                   (acc_use_imm || (acc_msel[SW-1] == acc_space));
  assign offset  = acc_use_imm ? acc_imm : mreg[acc_msel];
  assign cur_idx = ireg[acc_isel];
  assign sum     = cur_idx + offset;
  assign wb_en   = acc_valid && req_ok && (acc_post || acc_nomem);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NTOT; k++) begin
        ireg[k] <= '0;
        if (k == UP_SLOT)      mreg[k] <= DW'(1);
        else if (k == DN_SLOT) mreg[k] <= '1;
        else                   mreg[k] <= '0;
      end
    end else begin
      if (wr_en) begin
        if (wr_is_mod) mreg[wr_sel] <= wr_data;
        else           ireg[wr_sel] <= wr_data;
      end
      if (wb_en) ireg[acc_isel] <= sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
      bad_req    <= 1'b0;
    end else begin
      addr_valid <= acc_valid && req_ok && !acc_nomem;
      bad_req    <= acc_valid && !req_ok;
      if (acc_valid && req_ok && !acc_nomem)
        addr_out <= acc_post ? cur_idx : sum;
    end
  end
endmodule

// File: rtl/dag_dual_bank_chk.sv
module dag_dual_bank_chk #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_valid,
  input logic [$clog2(2*NREG)-1:0] acc_isel,
  input logic                      acc_post,
  input logic                      acc_nomem,
  input logic                      wr_en,
  input logic                      wr_is_mod,
  input logic [$clog2(2*NREG)-1:0] wr_sel,
  input logic                      req_ok,
  input logic [DW-1:0]             cur_idx,
  input logic [DW-1:0]             ireg [2*NREG],
  input logic [DW-1:0]             mreg [2*NREG],
  input logic [DW-1:0]             addr_out,
  input logic                      addr_valid,
  input logic                      bad_req
);
  AST_BAD_HIDES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |-> !addr_valid); // R5

  AST_BAD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |-> $past(acc_valid)); // R9

  AST_ADDR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(acc_valid && !acc_nomem)); // R9

  AST_RESET_MODS: assert property (@(posedge clk)
    $rose(rst_n) |-> (mreg[6] == DW'(1) && mreg[7] == '1)); // R1

  AST_PRE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && req_ok && !acc_nomem && !acc_post &&
          !(wr_en && !wr_is_mod && wr_sel == acc_isel))
    |-> ireg[$past(acc_isel)] == $past(cur_idx)); // R2

  AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(acc_post)) |-> addr_out == $past(cur_idx)); // R3
endmodule

bind dag_dual_bank dag_dual_bank_chk #(.DW(DW), .NREG(NREG)) chk_i (.*);

// File: tb/dag_dual_bank_tb_top.sv
module dag_dual_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_space = 0, acc_post = 0, acc_nomem = 0, acc_use_imm = 0;
  logic [3:0]  acc_isel = 0, acc_msel = 0, wr_sel = 0;
  logic [31:0] acc_imm = 0, wr_data = 0;
  logic        wr_en = 0, wr_is_mod = 0;
  logic [31:0] addr_out;
  logic        addr_valid, bad_req;

  int checks = 0, errors = 0;
  logic [31:0] got_addr;
  logic        got_valid, got_bad;

  always #10 clk = ~clk;

  dag_dual_bank dut_i (.*);

  typedef struct packed {
    logic sp; logic [3:0] is; logic [3:0] ms; logic post; logic ui;
    logic [31:0] imm; logic [31:0] ea; logic ev; logic eb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'd4,  4'd6,  1'b0, 1'b0, 32'd0,        32'h0000_1001, 1'b1, 1'b0}, // R2 M6=+1
    '{1'b0, 4'd4,  4'd4,  1'b1, 1'b0, 32'd0,        32'h0000_1000, 1'b1, 1'b0}, // R3
    '{1'b0, 4'd4,  4'd7,  1'b0, 1'b0, 32'd0,        32'h0000_100F, 1'b1, 1'b0}, // R2 M7=-1
    '{1'b0, 4'd4,  4'd0,  1'b1, 1'b1, 32'd8,        32'h0000_1010, 1'b1, 1'b0}, // R4 post imm
    '{1'b0, 4'd12, 4'd4,  1'b0, 1'b0, 32'd0,        32'h0,         1'b0, 1'b1}, // R5 data with I12
    '{1'b0, 4'd4,  4'd15, 1'b1, 1'b0, 32'd0,        32'h0,         1'b0, 1'b1}, // R5 data with M15
    '{1'b1, 4'd12, 4'd12, 1'b1, 1'b0, 32'd0,        32'h0000_2000, 1'b1, 1'b0}, // R3 program bank
    '{1'b1, 4'd12, 4'd0,  1'b0, 1'b1, 32'hFFFF_FFFF,32'h0000_1FEF, 1'b1, 1'b0}, // R4 imm -1
    '{1'b1, 4'd4,  4'd12, 1'b0, 1'b0, 32'd0,        32'h0,         1'b0, 1'b1}, // R5 program with I4
    '{1'b0, 4'd4,  4'd7,  1'b1, 1'b0, 32'd0,        32'h0000_1018, 1'b1, 1'b0}, // R3, R5 no wb on bad
    '{1'b0, 4'd4,  4'd0,  1'b0, 1'b1, 32'd0,        32'h0000_1017, 1'b1, 1'b0}, // R2 readback
    '{1'b1, 4'd12, 4'd0,  1'b0, 1'b1, 32'd0,        32'h0000_1FF0, 1'b1, 1'b0}, // R2 I12 kept
    '{1'b0, 4'd4,  4'd12, 1'b0, 1'b1, 32'd4,        32'h0000_101B, 1'b1, 1'b0}  // R4 msel ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic sp, input logic [3:0] is, input logic [3:0] ms,
                       input logic post, input logic nomem, input logic ui,
                       input logic [31:0] imm);
    acc_valid = 1; acc_space = sp; acc_isel = is; acc_msel = ms;
    acc_post = post; acc_nomem = nomem; acc_use_imm = ui; acc_imm = imm;
    @(negedge clk);
    acc_valid = 0; acc_nomem = 0;
    got_addr = addr_out; got_valid = addr_valid; got_bad = bad_req;
  endtask

  task automatic wr_reg(input logic ismod, input logic [3:0] sel, input logic [31:0] d);
    wr_en = 1; wr_is_mod = ismod; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic peek_i(input logic [3:0] sel, output logic [31:0] v);
    issue(sel[3], sel, 4'd0, 1'b0, 1'b0, 1'b1, 32'd0);
    v = got_addr;
  endtask

  task automatic peek_m(input logic [3:0] sel, output logic [31:0] v);
    issue(sel[3], {sel[3], 3'd0}, sel, 1'b0, 1'b0, 1'b0, 32'd0);
    v = got_addr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 addr_valid", {31'd0, addr_valid}, 32'd0);
    chk("R1 bad_req", {31'd0, bad_req}, 32'd0);
    peek_m(4'd6, v);  chk("R1 M6", v, 32'd1);
    peek_m(4'd7, v);  chk("R1 M7", v, 32'hFFFF_FFFF);
    peek_m(4'd5, v);  chk("R1 M5", v, 32'd0);
    peek_m(4'd14, v); chk("R1 M14", v, 32'd0);
    peek_i(4'd9, v);  chk("R1 I9", v, 32'd0);

    wr_reg(1'b0, 4'd4, 32'h1000);
    wr_reg(1'b0, 4'd12, 32'h2000);
    wr_reg(1'b1, 4'd4, 32'h10);
    wr_reg(1'b1, 4'd12, 32'hFFFF_FFF0);

    for (int n = 0; n < NV; n++) begin
      string tag;
      tag = TBL[n].eb ? "R5" : TBL[n].ui ? "R4" : TBL[n].post ? "R3" : "R2";
      issue(TBL[n].sp, TBL[n].is, TBL[n].ms, TBL[n].post, 1'b0, TBL[n].ui, TBL[n].imm);
      chk($sformatf("%s vec%0d valid", tag, n), {31'd0, got_valid}, {31'd0, TBL[n].ev});
      chk($sformatf("%s vec%0d bad", tag, n), {31'd0, got_bad}, {31'd0, TBL[n].eb});
      if (TBL[n].ev) chk($sformatf("%s vec%0d addr", tag, n), got_addr, TBL[n].ea);
    end

    // R9 bad_req lasts one cycle
    issue(1'b1, 4'd3, 4'd9, 1'b0, 1'b0, 1'b0, 32'd0);
    chk("R9 bad pulse on", {31'd0, got_bad}, 32'd1);
    @(negedge clk);
    chk("R9 bad pulse off", {31'd0, bad_req}, 32'd0);

    // R6 modify-only walks down, no address
    wr_reg(1'b0, 4'd2, 32'h50);
    issue(1'b0, 4'd2, 4'd7, 1'b0, 1'b1, 1'b0, 32'd0);
    chk("R6 no valid", {31'd0, got_valid}, 32'd0);
    peek_i(4'd2, v); chk("R6 index", v, 32'h4F);
    issue(1'b0, 4'd10, 4'd7, 1'b0, 1'b1, 1'b0, 32'd0);
    chk("R5 modify-only bad", {31'd0, got_bad}, 32'd1);

    // R8 wrap
    wr_reg(1'b0, 4'd3, 32'hFFFF_FFFF);
    issue(1'b0, 4'd3, 4'd0, 1'b1, 1'b0, 1'b1, 32'd1);
    chk("R8 addr", got_addr, 32'hFFFF_FFFF);
    peek_i(4'd3, v); chk("R8 wrapped", v, 32'd0);

    // R7 modify write and collision
    wr_reg(1'b1, 4'd5, 32'h20);
    peek_m(4'd5, v); chk("R7 M5 write", v, 32'h20);
    wr_reg(1'b0, 4'd6, 32'h100);
    wr_en = 1; wr_is_mod = 0; wr_sel = 4'd6; wr_data = 32'h777;
    issue(1'b0, 4'd6, 4'd0, 1'b1, 1'b0, 1'b1, 32'd4);
    wr_en = 0;
    chk("R7 collision addr", got_addr, 32'h100);
    peek_i(4'd6, v); chk("R7 writeback wins", v, 32'h104);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule